// File: doc/BRIEF.md
# Integer ALU with status flags

This block is the integer arithmetic and logic unit of an execution pipeline. Each cycle it may accept one operation. The operation consists of an opcode, a size select, two source operands and the current carry flag. One clock later the block returns three things. The first is the result. The second is a strobe that says whether the destination is to be written. The third is the carry, overflow, zero and sign flags, each paired with its own update mask. Flags whose mask is set replace the architectural flags. Flags whose mask is clear keep their old value.

The operand width is chosen per operation as 8, 16 or 32 bits. Only the low bits of each operand at that width take part in the operation. Every flag is taken at that width. The supported operations are:
- plain and carry-chained addition and subtraction
- increment and decrement
- two's-complement negation
- AND, OR, XOR and one's complement
- a flag-only AND test

The operations differ in which flags they touch. Increment and decrement leave carry alone. One's complement touches no flag. The test operation never writes its destination.

Top module: `alu_flags_top`

## Requirements
- R1: Opcode encoding on `opCode`: 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 AND, 8 OR, 9 XOR, 10 NOT, 11 TEST. Codes 12 to 15 are no-ops: the result is zero, `destWrite` is low and all update masks are clear.
- R2: Size encoding on `sizeSel`: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width are zero and all flags come from the selected width. For example, 0x00FF + 1 gives result 0 with carry set at 8 bits, and gives 0x0100 with carry clear at 16 bits.
- R3: The arithmetic results are taken modulo 2^width:
  - add gives a+b
  - subtract gives a-b
  - add-with-carry gives a+b+carryIn
  - subtract-with-borrow gives a-b-carryIn
- R4: Carry is the unsigned carry out of add and add-with-carry. For subtract and subtract-with-borrow, carry is the unsigned borrow, which is set when a < b (+carryIn).
- R5: Overflow is set when the true signed result of an add, subtract, increment, decrement or negate falls outside the signed range of the width. For example, 42+87 at 8 bits gives 0x81 with overflow set, and (-42)+(-87) gives 0x7F with overflow set.
- R6: Whenever the zero and sign masks are set, zero reports a result of all zeros at the selected width and sign reports the top bit at that width.
- R7: Increment and decrement return a+1 and a-1. They update overflow, zero and sign, and leave the carry mask clear.
- R8: Negate returns 0-a and updates all four flags. Carry is set exactly when a is non-zero.
- R9: AND, OR and XOR return the bitwise result and update all four flags. Carry and overflow are forced to 0.
- R10: TEST returns a AND b on `result` and sets the flags as AND does, but `destWrite` stays low.
- R11: NOT returns the one's complement of a, raises `destWrite`, and clears every update mask.
- R12: Results appear with `resValid` one cycle after `opValid`. A cycle without `opValid` is followed by a cycle with `resValid`, `destWrite`, `result`, every mask and every flag at 0. The flag value outputs are 0 whenever their mask is clear.
- R13: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code (R1) |
| sizeSel | input | 2 | Operand width select (R2) |
| srcA | input | DATA_W | First operand; sole operand of the unary ops |
| srcB | input | DATA_W | Second operand |
| carryIn | input | 1 | Current carry flag |
| resValid | output | 1 | Outputs below belong to the previous cycle's operation |
| result | output | DATA_W | Result, zero above the selected width |
| destWrite | output | 1 | Destination is to be written |
| carryFlag | output | 1 | New carry value |
| ovfFlag | output | 1 | New overflow value |
| zeroFlag | output | 1 | New zero value |
| signFlag | output | 1 | New sign value |
| carryUpd | output | 1 | Carry is to be updated |
| ovfUpd | output | 1 | Overflow is to be updated |
| zeroUpd | output | 1 | Zero is to be updated |
| signUpd | output | 1 | Sign is to be updated |

## Verification
Every result, flag, mask and write strobe passes through exactly one register. All of them are therefore due on the first rising edge after the operation is presented. The bench drives each operation on a falling edge and compares the whole output bundle on the next falling edge. That edge lies half a period after the capturing edge, so the sample always lands where the answer is stable. The expected bundle is worked out by integer arithmetic on the operands. Overflow is judged from the true signed sum, and borrow is judged from an unsigned comparison. The bench sweeps every opcode against many 8-bit operand pairs and against edge-value pairs at the wider sizes.

// File: rtl/alu_flags_pkg.sv
`timescale 1ns/1ps
package alu_flags_pkg;

  // opcode values seen on the opCode port
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOT  = 4'd10,
    OP_TEST = 4'd11
  } aluOp_e;

  // carry-in source for the adder
  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG, CIN_NFLAG
  } cinSel_e;

  typedef enum logic [1:0] {
    LOG_AND, LOG_OR, LOG_XOR, LOG_NOT
  } logicSel_e;

  // strobes from control to datapath / output stage
  typedef struct packed {
    logic      legal;
    logic      arith;     // adder result, else logic result
    logic      negate;    // adder computes 0 - srcA
    logic      constB;    // second adder input is the constant one
    logic      invB;      // invert second adder input
    cinSel_e   cinSel;
    logic      borrow;    // carry flag reports borrow
    logicSel_e logicSel;
    logic      wrDest;
    logic      updC;
    logic      updV;
    logic      updZS;
  } aluCtrl_t;

endpackage

// File: rtl/alu_flags_ctrl.sv
`timescale 1ns/1ps
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.legal  = 1'b1;
    ctrl.wrDest = 1'b1;
    ctrl.updC   = 1'b1;
    ctrl.updV   = 1'b1;
    ctrl.updZS  = 1'b1;
    case (opCode)
      OP_ADD: ctrl.arith = 1'b1;
      OP_ADC: begin
        ctrl.arith  = 1'b1;
        ctrl.cinSel = CIN_FLAG;
      end
      OP_SUB: begin
        ctrl.arith  = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
        ctrl.borrow = 1'b1;
      end
      OP_SBB: begin
        ctrl.arith  = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_NFLAG;
        ctrl.borrow = 1'b1;
      end
      OP_INC: begin
        ctrl.arith  = 1'b1;
        ctrl.constB = 1'b1;
        ctrl.updC   = 1'b0;
      end
      OP_DEC: begin
        ctrl.arith  = 1'b1;
        ctrl.constB = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
        ctrl.updC   = 1'b0;
      end
      OP_NEG: begin
        ctrl.arith  = 1'b1;
        ctrl.negate = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
        ctrl.borrow = 1'b1;
      end
      OP_AND:  ctrl.logicSel = LOG_AND;
      OP_OR:   ctrl.logicSel = LOG_OR;
      OP_XOR:  ctrl.logicSel = LOG_XOR;
      OP_NOT: begin
        ctrl.logicSel = LOG_NOT;
        ctrl.updC  = 1'b0;
        ctrl.updV  = 1'b0;
        ctrl.updZS = 1'b0;
      end
      OP_TEST: begin
        ctrl.logicSel = LOG_AND;
        ctrl.wrDest   = 1'b0;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/alu_flags_dpath.sv
`timescale 1ns/1ps
module alu_flags_dpath
  import alu_flags_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  aluCtrl_t          ctrl,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] res,
  output logic              cOut,
  output logic              vOut,
  output logic              zOut,
  output logic              sOut
);

  localparam logic [DATA_W-1:0] MASK_N = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_M = {{(DATA_W-MID_W){1'b0}}, {MID_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE_W  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] widthMask, aOp, bRaw, bOp, arithRes, logicRes;
  logic [DATA_W:0]   sumFull;
  logic              cin, cRaw, aTop, bTop, rTop;

  always_comb begin
    case (sizeSel)
      2'd0:    widthMask = MASK_N;
      2'd1:    widthMask = MASK_M;
      default: widthMask = '1;
    endcase
  end

  always_comb begin
    aOp  = ctrl.negate ? '0 : (srcA & widthMask);
    bRaw = ctrl.negate ? srcA : (ctrl.constB ? ONE_W : srcB);
    bOp  = (ctrl.invB ? ~bRaw : bRaw) & widthMask;
    case (ctrl.cinSel)
      CIN_ZERO:  cin = 1'b0;
      CIN_ONE:   cin = 1'b1;
      CIN_FLAG:  cin = carryIn;
      default:   cin = ~carryIn;
    endcase
    sumFull  = {1'b0, aOp} + {1'b0, bOp} + {{DATA_W{1'b0}}, cin};
    arithRes = sumFull[DATA_W-1:0] & widthMask;
    case (ctrl.logicSel)
      LOG_AND: logicRes = srcA & srcB;
      LOG_OR:  logicRes = srcA | srcB;
      LOG_XOR: logicRes = srcA ^ srcB;
      default: logicRes = ~srcA;
    endcase
    res = ctrl.arith ? arithRes : (logicRes & widthMask);
  end

  // top-of-width bits
  always_comb begin
    case (sizeSel)
      2'd0: begin
        cRaw = sumFull[NARROW_W];
        aTop = aOp[NARROW_W-1];
        bTop = bOp[NARROW_W-1];
        rTop = res[NARROW_W-1];
      end
      2'd1: begin
        cRaw = sumFull[MID_W];
        aTop = aOp[MID_W-1];
        bTop = bOp[MID_W-1];
        rTop = res[MID_W-1];
      end
      default: begin
        cRaw = sumFull[DATA_W];
        aTop = aOp[DATA_W-1];
        bTop = bOp[DATA_W-1];
        rTop = res[DATA_W-1];
      end
    endcase
    cOut = ctrl.arith & (cRaw ^ ctrl.borrow);
    vOut = ctrl.arith & (aTop == bTop) & (rTop != aTop);
    zOut = (res == '0);
    sOut = rTop;
  end

endmodule

// File: rtl/alu_flags_top.sv
`timescale 1ns/1ps
module alu_flags_top
  import alu_flags_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              carryIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              destWrite,
  output logic              carryFlag,
  output logic              ovfFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              carryUpd,
  output logic              ovfUpd,
  output logic              zeroUpd,
  output logic              signUpd
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] dpRes;
  logic              dpC, dpV, dpZ, dpS, take;

  alu_flags_ctrl ctrlI (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_flags_dpath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .MID_W    (MID_W)
  ) dpathI (
    .ctrl    (ctrl),
    .sizeSel (sizeSel),
    .srcA    (srcA),
    .srcB    (srcB),
    .carryIn (carryIn),
    .res     (dpRes),
    .cOut    (dpC),
    .vOut    (dpV),
    .zOut    (dpZ),
    .sOut    (dpS)
  );

  always_comb take = opValid & ctrl.legal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      result    <= '0;
      destWrite <= 1'b0;
      carryFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      zeroFlag  <= 1'b0;
      signFlag  <= 1'b0;
      carryUpd  <= 1'b0;
      ovfUpd    <= 1'b0;
      zeroUpd   <= 1'b0;
      signUpd   <= 1'b0;
    end else begin
      resValid  <= opValid;
      result    <= take ? dpRes : '0;
      destWrite <= take & ctrl.wrDest;
      carryUpd  <= take & ctrl.updC;
      ovfUpd    <= take & ctrl.updV;
      zeroUpd   <= take & ctrl.updZS;
      signUpd   <= take & ctrl.updZS;
      carryFlag <= take & ctrl.updC & dpC;
      ovfFlag   <= take & ctrl.updV & dpV;
      zeroFlag  <= take & ctrl.updZS & dpZ;
      signFlag  <= take & ctrl.updZS & dpS;
    end
  end

endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [1:0]        sizeSel,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              destWrite,
  input logic              carryFlag,
  input logic              ovfFlag,
  input logic              zeroFlag,
  input logic              carryUpd,
  input logic              ovfUpd,
  input logic              zeroUpd,
  input logic              signUpd
);

  // R10
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_TEST |=> resValid && !destWrite && zeroUpd);

  // R11
  not_noflags_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_NOT |=> destWrite && !carryUpd && !ovfUpd && !zeroUpd && !signUpd);

  // R7
  incdec_keepc_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode == OP_INC || opCode == OP_DEC) |=> !carryUpd && ovfUpd && zeroUpd);

  // R9
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR)
    |=> carryUpd && ovfUpd && !carryFlag && !ovfFlag);

  // R6
  zero_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroUpd |-> zeroFlag == (result == '0));

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && sizeSel == 2'd0 |=> result[DATA_W-1:NARROW_W] == '0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid && !destWrite && !zeroUpd && !carryUpd);

  // R1
  illegal_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode >= 4'd12 |=> resValid && !destWrite && !carryUpd && !ovfUpd && !zeroUpd);

endmodule

bind alu_flags_top alu_flags_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chkI (.*);

// File: tb/alu_flags_top_tb_top.sv
`timescale 1ns/1ps
module alu_flags_top_tb_top;

  typedef struct packed {
    logic        vld;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  upd;  // carry, ovf, zero, sign
    logic [3:0]  fl;
  } obs_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic        carryIn = 1'b0;
  logic        resValid, destWrite, carryFlag, ovfFlag, zeroFlag, signFlag;
  logic        carryUpd, ovfUpd, zeroUpd, signUpd;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu_flags_top dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .sizeSel(sizeSel),
    .srcA(srcA), .srcB(srcB), .carryIn(carryIn), .resValid(resValid), .result(result),
    .destWrite(destWrite), .carryFlag(carryFlag), .ovfFlag(ovfFlag), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .carryUpd(carryUpd), .ovfUpd(ovfUpd), .zeroUpd(zeroUpd),
    .signUpd(signUpd)
  );

  function automatic obs_t observe();
    obs_t o;
    o.vld = resValid;
    o.res = result;
    o.wr  = destWrite;
    o.upd = {carryUpd, ovfUpd, zeroUpd, signUpd};
    o.fl  = {carryFlag, ovfFlag, zeroFlag, signFlag};
    return o;
  endfunction

  // expected bundle, from integer arithmetic on the operands
  function automatic obs_t model(int op, int sz, logic [31:0] a, logic [31:0] b, logic cf);
    obs_t e;
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    longint unsigned m  = (64'd1 << w) - 1;
    longint unsigned am = {32'd0, a} & m;
    longint unsigned bm = {32'd0, b} & m;
    longint unsigned cv = {63'd0, cf};
    longint sa = (am >> (w - 1)) != 0 ? longint'(am) - (longint'(1) << w) : longint'(am);
    longint sb = (bm >> (w - 1)) != 0 ? longint'(bm) - (longint'(1) << w) : longint'(bm);
    longint maxS = (longint'(1) << (w - 1)) - 1;
    longint minS = -(longint'(1) << (w - 1));
    longint unsigned r = 0;
    longint sr = 0;
    logic c = 0, v = 0, z, s;
    e = '0;
    e.vld = 1'b1;
    e.wr  = 1'b1;
    e.upd = 4'b1111;
    case (op)
      0: begin r = am + bm; sr = sa + sb; c = r > m; end
      2: begin r = am + bm + cv; sr = sa + sb + longint'(cv); c = r > m; end
      1: begin r = am - bm; sr = sa - sb; c = am < bm; end
      3: begin r = am - bm - cv; sr = sa - sb - longint'(cv); c = am < bm + cv; end
      4: begin r = am + 1; sr = sa + 1; e.upd = 4'b0111; end
      5: begin r = am - 1; sr = sa - 1; e.upd = 4'b0111; end
      6: begin r = 0 - am; sr = -sa; c = am != 0; end
      7: r = am & bm;
      8: r = am | bm;
      9: r = am ^ bm;
      10: begin r = ~am; e.upd = 4'b0000; end
      11: begin r = am & bm; e.wr = 1'b0; end
      default: begin e.wr = 1'b0; e.upd = 4'b0000; end
    endcase
    if (op <= 6) v = (sr > maxS) || (sr < minS);
    r = r & m;
    if (op > 11) r = 0;
    z = (r == 0);
    s = ((r >> (w - 1)) & 1) != 0;
    e.res = r[31:0];
    e.fl  = e.upd & {c, v, z, s};
    return e;
  endfunction

  function automatic string opTag(int op);
    if (op <= 3) return "R3";
    if (op <= 5) return "R7";
    if (op == 6) return "R8";
    if (op <= 9) return "R9";
    if (op == 10) return "R11";
    if (op == 11) return "R10";
    return "R1";
  endfunction

  task automatic compare(string tag, obs_t got, obs_t exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual vld=%0b res=%h wr=%0b upd=%b fl=%b expected vld=%0b res=%h wr=%0b upd=%b fl=%b",
               tag, got.vld, got.res, got.wr, got.upd, got.fl,
               exp.vld, exp.res, exp.wr, exp.upd, exp.fl);
    end
  endtask

  task automatic chkVal(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic doOp(string tag, int op, int sz, logic [31:0] a, logic [31:0] b, logic cf);
    opValid = 1'b1;
    opCode  = op[3:0];
    sizeSel = sz[1:0];
    srcA    = a;
    srcB    = b;
    carryIn = cf;
    @(negedge clk);
    compare(tag, observe(), model(op, sz, a, b, cf));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0]  edge8 [8]  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h2A, 8'h57, 8'hD6};
    logic [31:0] edgeW [9]  = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF,
                                32'h12345678, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF};
    obs_t o;
    repeat (3) @(negedge clk);
    // R13: reset state while reset held
    opValid = 1'b1;
    opCode  = 4'd0;
    @(negedge clk);
    o = observe();
    chkVal("R13", {o.vld, o.wr, o.upd, o.fl}, '0);
    chkVal("R13", o.res, '0);
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // directed boundary cases
    doOp("R2", 0, 0, 32'h00FF, 32'h1, 1'b0);
    chkVal("R2", {result, 31'd0, carryFlag}, {32'h0, 31'd0, 1'b1});
    doOp("R2", 0, 1, 32'h00FF, 32'h1, 1'b0);
    chkVal("R2", {result, 31'd0, carryFlag}, {32'h100, 31'd0, 1'b0});
    doOp("R5", 0, 0, 32'd42, 32'd87, 1'b0);
    chkVal("R5", {result, 31'd0, ovfFlag}, {32'h81, 31'd0, 1'b1});
    doOp("R5", 0, 0, 32'hD6, 32'hA9, 1'b0);
    chkVal("R5", {result, 31'd0, ovfFlag}, {32'h7F, 31'd0, 1'b1});
    doOp("R4", 1, 0, 32'd3, 32'd5, 1'b0);
    chkVal("R4", {result, 31'd0, carryFlag}, {32'hFE, 31'd0, 1'b1});
    doOp("R4", 3, 1, 32'd5, 32'd5, 1'b1);
    chkVal("R4", {result, 31'd0, carryFlag}, {32'hFFFF, 31'd0, 1'b1});
    doOp("R6", 0, 0, 32'h100, 32'h0, 1'b0);
    chkVal("R6", {31'd0, zeroFlag}, 32'd1);
    doOp("R6", 9, 2, 32'h80000000, 32'h0, 1'b0);
    chkVal("R6", {30'd0, zeroFlag, signFlag}, 32'd1);
    doOp("R8", 6, 0, 32'h80, 32'h0, 1'b0);
    chkVal("R8", {result, 30'd0, carryFlag, ovfFlag}, {32'h80, 30'd0, 2'b11});
    doOp("R8", 6, 2, 32'h0, 32'h0, 1'b1);
    chkVal("R8", {31'd0, carryFlag}, 32'd0);

    // R12: idle cycle
    opValid = 1'b0;
    @(negedge clk);
    compare("R12", observe(), '0);

    // 8-bit sweep over all opcodes
    for (int op = 0; op < 16; op++)
      for (int cf = 0; cf < 2; cf++)
        for (int a = 0; a < 256; a += 5)
          for (int bi = 0; bi < 8; bi++)
            doOp(opTag(op), op, 0, a, {24'h0, edge8[bi]}, cf[0]);

    // wider sizes over edge values, size 3 aliasing 32 bits (R2)
    for (int sz = 1; sz < 4; sz++)
      for (int op = 0; op < 16; op++)
        for (int cf = 0; cf < 2; cf++)
          for (int ai = 0; ai < 9; ai++)
            for (int bi = 0; bi < 9; bi++)
              doOp(sz == 3 ? "R2" : opTag(op), op, sz, edgeW[ai], edgeW[bi], cf[0]);

    opValid = 1'b0;
    @(negedge clk);
    compare("R12", observe(), '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule